// File: doc/BRIEF.md
# Two-Stage Deadline Watchdog

This block is a watchdog timer that does not count down. It keeps an absolute 64-bit deadline and compares it with a free-running system count that it receives from outside. Software picks a 32-bit period. Each refresh moves the deadline to the current count plus that period.

The first time the count reaches the deadline, the block raises an alert that is meant to drive an interrupt line. It then moves the deadline forward by one more period. If the count reaches the new deadline before any refresh arrives, the block raises a trip output that is meant to request a system reset. The trip output then stays high until a refresh or a power-on reset, so software can still read it after the reset it caused.

The block is reached over a simple single-cycle memory-mapped bus with two frames, selected by `bus_kick_frame`:
- The kick frame holds one write-only refresh location.
- The control frame holds the control/status word, the period, and the two halves of the deadline.

A four-state machine sets the behaviour:
- OFF: the watchdog is disabled.
- ARMED: the first period is running.
- ALERT: the alert is raised and the second period is running.
- TRIPPED: both outputs are raised.

Its named transitions are:
- enable: OFF to ARMED, on a control write with bit 0 set.
- disable: any state to OFF, on a control write with bit 0 clear.
- kick: ARMED, ALERT or TRIPPED back to ARMED, on any refresh while enabled.
- first_expiry: ARMED to ALERT.
- second_expiry: ALERT to TRIPPED.

Top module: `dual_stage_wdt`

## Requirements
- R1: After reset, `alert` and `trip` are low, and every control-frame register reads 0: control, period, deadline low word and deadline high word.
- R2: The control word is at control-frame offset 0x000. Bit 0 is the enable bit, bit 1 shows the alert flag, and bit 2 shows the trip flag. Any write to it sets the enable bit from data bit 0 and is also a refresh, so writing 0 disables the watchdog and clears both flags.
- R3: A write of any data to kick-frame offset 0x000 is a refresh. It loads the deadline with the count sampled at that write plus the period, and it clears `alert` and `trip`.
- R4: The period is a 32-bit read/write register at control-frame offset 0x008. While the watchdog is enabled, a write to it is also a refresh that uses the new value. While the watchdog is disabled, a write to it leaves the deadline unchanged.
- R5: The deadline reads as a 64-bit value in two words: bits 31:0 at control-frame offset 0x010 and bits 63:32 at 0x014.
- R6: While ARMED, once the count is at or past the deadline, `alert` rises, and the deadline is reloaded with that count plus the period. With period P, counted from the clock edge of the refresh, `alert` is first high after edge max(P,1).
- R7: While ALERT, once the count is at or past the deadline, `trip` rises. With no refresh in between, this happens after edge 2*max(P,1), and `trip` never rises while `alert` is low.
- R8: Once high, `trip` and `alert` stay high until a refresh or a reset, however long the count keeps running.
- R9: While disabled, neither stage output changes however far the count advances.
- R10: A refresh in the same cycle as an expiry wins: no stage advances, and the deadline takes the refresh value.
- R11: Read data appears on `bus_rdata` in the cycle after the read strobe. Reads of the kick frame, and of unmapped control-frame offsets, return 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| sys_count | input | 64 | Free-running system count |
| bus_kick_frame | input | 1 | Frame select: 1 = kick frame, 0 = control frame |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_addr | input | 12 | Byte offset within the selected frame |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| alert | output | 1 | First-stage expiry (interrupt request) |
| trip | output | 1 | Second-stage expiry (reset request) |

## Verification
The assertions assume the following about the inputs:
- `sys_count` rises by at most one step per cycle and never wraps, so a deadline computed at a refresh lies ahead of the count.
- Read and write strobes are never asserted together.

The bench keeps within these limits:
- It increments its own count by exactly one per clock.
- It starts the count just below a 32-bit carry, so deadlines cross into the high word without coming near a 64-bit wrap.
- It issues every bus access as a single-cycle strobe launched on the falling clock edge.

// File: rtl/dual_stage_wdt_pkg.sv
`timescale 1ns/1ps
package dual_stage_wdt_pkg;
    typedef enum logic [1:0] {
        ST_OFF     = 2'd0,
        ST_ARMED   = 2'd1,
        ST_ALERT   = 2'd2,
        ST_TRIPPED = 2'd3
    } wdt_state_e;

    localparam int OFS_KICK     = 'h000;
    localparam int OFS_CTRL     = 'h000;
    localparam int OFS_PERIOD   = 'h008;
    localparam int OFS_DL_LO    = 'h010;
    localparam int OFS_DL_HI    = 'h014;

    localparam int CTRL_EN_BIT  = 0;
    localparam int CTRL_AL_BIT  = 1;
    localparam int CTRL_TR_BIT  = 2;
endpackage

// File: rtl/wdt_regs.sv
`timescale 1ns/1ps
module wdt_regs
    import dual_stage_wdt_pkg::*;
#(
    parameter int ADDR_W   = 12,
    parameter int DATA_W   = 32,
    parameter int PERIOD_W = 32,
    parameter int CNT_W    = 64
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_kick_frame,
    input  logic                bus_wr,
    input  logic                bus_rd,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [DATA_W-1:0]   bus_wdata,
    input  logic                enabled,
    input  logic                ws_alert,
    input  logic                ws_trip,
    input  logic [CNT_W-1:0]    deadline,
    output logic                refresh,
    output logic                ctrl_wr,
    output logic [PERIOD_W-1:0] period_q,
    output logic [PERIOD_W-1:0] load_period,
    output logic [DATA_W-1:0]   bus_rdata
);
    localparam int WIDE_W = 2 * DATA_W;

    logic kick_wr;
    logic period_wr;
    logic [DATA_W-1:0] rd_mux;
    logic [DATA_W-1:0] period_ext;
    logic [DATA_W-1:0] status_word;
    logic [WIDE_W-1:0] dl_wide;

    always_comb begin
        kick_wr   = bus_wr &&  bus_kick_frame && (bus_addr == ADDR_W'(OFS_KICK));
        ctrl_wr   = bus_wr && !bus_kick_frame && (bus_addr == ADDR_W'(OFS_CTRL));
        period_wr = bus_wr && !bus_kick_frame && (bus_addr == ADDR_W'(OFS_PERIOD));
        refresh   = kick_wr || ctrl_wr || (period_wr && enabled);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            period_q <= '0;
        else if (period_wr)
            period_q <= bus_wdata[PERIOD_W-1:0];
    end

    assign load_period = period_wr ? bus_wdata[PERIOD_W-1:0] : period_q;

    always_comb begin
        period_ext = '0;
        period_ext[PERIOD_W-1:0] = period_q;
        status_word = '0;
        status_word[CTRL_EN_BIT] = enabled;
        status_word[CTRL_AL_BIT] = ws_alert;
        status_word[CTRL_TR_BIT] = ws_trip;
        dl_wide = WIDE_W'(deadline);
        rd_mux = '0;
        if (!bus_kick_frame) begin
            unique case (bus_addr)
                ADDR_W'(OFS_CTRL):   rd_mux = status_word;
                ADDR_W'(OFS_PERIOD): rd_mux = period_ext;
                ADDR_W'(OFS_DL_LO):  rd_mux = dl_wide[DATA_W-1:0];
                ADDR_W'(OFS_DL_HI):  rd_mux = dl_wide[WIDE_W-1:DATA_W];
                default:             rd_mux = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            bus_rdata <= '0;
        else
            bus_rdata <= bus_rd ? rd_mux : '0;
    end

    // R4: a period write while disabled must not count as a refresh
    p_period_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (period_wr && !enabled && !bus_kick_frame) |-> !refresh);
endmodule

// File: rtl/wdt_deadline.sv
`timescale 1ns/1ps
module wdt_deadline #(
    parameter int CNT_W    = 64,
    parameter int PERIOD_W = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [CNT_W-1:0]    sys_count,
    input  logic                refresh,
    input  logic                stage_reload,
    input  logic [PERIOD_W-1:0] load_period,
    input  logic [PERIOD_W-1:0] period_q,
    output logic [CNT_W-1:0]    deadline,
    output logic                reached
);
    logic [CNT_W-1:0] deadline_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            deadline_q <= '0;
        else if (refresh)
            deadline_q <= sys_count + CNT_W'(load_period);
        else if (stage_reload)
            deadline_q <= sys_count + CNT_W'(period_q);
    end

    assign deadline = deadline_q;
    assign reached  = (sys_count >= deadline_q);

    // R10: a deadline change is only ever caused by a refresh or a stage reload
    p_deadline_source_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!refresh && !stage_reload) |=> $stable(deadline_q));
endmodule

// File: rtl/wdt_fsm.sv
`timescale 1ns/1ps
module wdt_fsm
    import dual_stage_wdt_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic refresh,
    input  logic ctrl_wr,
    input  logic ctrl_en_bit,
    input  logic reached,
    output logic enabled,
    output logic ws_alert,
    output logic ws_trip,
    output logic stage_reload
);
    wdt_state_e state_q;
    wdt_state_e state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_OFF;
        else
            state_q <= state_d;
    end

    always_comb begin
        state_d      = state_q;
        stage_reload = 1'b0;
        if (refresh) begin
            if (ctrl_wr)
                state_d = ctrl_en_bit ? ST_ARMED : ST_OFF;
            else if (state_q != ST_OFF)
                state_d = ST_ARMED;
        end else begin
            unique case (state_q)
                ST_OFF:     state_d = ST_OFF;
                ST_ARMED: begin
                    if (reached) begin
                        state_d      = ST_ALERT;
                        stage_reload = 1'b1;
                    end
                end
                ST_ALERT:   if (reached) state_d = ST_TRIPPED;
                ST_TRIPPED: state_d = ST_TRIPPED;
            endcase
        end
    end

    always_comb begin
        enabled  = 1'b0;
        ws_alert = 1'b0;
        ws_trip  = 1'b0;
        unique case (state_q)
            ST_OFF:     ;
            ST_ARMED:   enabled = 1'b1;
            ST_ALERT: begin
                enabled  = 1'b1;
                ws_alert = 1'b1;
            end
            ST_TRIPPED: begin
                enabled  = 1'b1;
                ws_alert = 1'b1;
                ws_trip  = 1'b1;
            end
        endcase
    end

    // R3: a refresh always leaves both stage flags clear
    p_refresh_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
        refresh |=> (!ws_alert && !ws_trip));
    // R7: the trip stage is only entered from the alert stage
    p_stage_order_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ws_trip) |-> $past(ws_alert));
    // R8: trip holds until a refresh
    p_trip_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ws_trip && !refresh) |=> ws_trip);
    // R9: a disabled watchdog stays disabled without a refresh
    p_off_holds_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!enabled && !refresh) |=> (!enabled && !ws_alert && !ws_trip));
    // R6: stage flags move only on a reached deadline or a refresh
    p_no_spurious_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!reached && !refresh) |=> ($stable(ws_alert) && $stable(ws_trip)));
endmodule

// File: rtl/dual_stage_wdt.sv
`timescale 1ns/1ps
module dual_stage_wdt #(
    parameter int ADDR_W   = 12,
    parameter int DATA_W   = 32,
    parameter int PERIOD_W = 32,
    parameter int CNT_W    = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CNT_W-1:0]  sys_count,
    input  logic              bus_kick_frame,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              alert,
    output logic              trip
);
    logic                refresh;
    logic                ctrl_wr;
    logic                enabled;
    logic                ws_alert;
    logic                ws_trip;
    logic                stage_reload;
    logic                reached;
    logic [PERIOD_W-1:0] period_q;
    logic [PERIOD_W-1:0] load_period;
    logic [CNT_W-1:0]    deadline;

    wdt_regs #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PERIOD_W(PERIOD_W), .CNT_W(CNT_W)
    ) u_regs (
        .clk(clk), .rst_n(rst_n),
        .bus_kick_frame(bus_kick_frame), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .enabled(enabled), .ws_alert(ws_alert), .ws_trip(ws_trip),
        .deadline(deadline),
        .refresh(refresh), .ctrl_wr(ctrl_wr),
        .period_q(period_q), .load_period(load_period),
        .bus_rdata(bus_rdata)
    );

    wdt_deadline #(
        .CNT_W(CNT_W), .PERIOD_W(PERIOD_W)
    ) u_deadline (
        .clk(clk), .rst_n(rst_n), .sys_count(sys_count),
        .refresh(refresh), .stage_reload(stage_reload),
        .load_period(load_period), .period_q(period_q),
        .deadline(deadline), .reached(reached)
    );

    wdt_fsm u_fsm (
        .clk(clk), .rst_n(rst_n),
        .refresh(refresh), .ctrl_wr(ctrl_wr), .ctrl_en_bit(bus_wdata[0]),
        .reached(reached),
        .enabled(enabled), .ws_alert(ws_alert), .ws_trip(ws_trip),
        .stage_reload(stage_reload)
    );

    assign alert = ws_alert;
    assign trip  = ws_trip;
endmodule

// File: tb/dual_stage_wdt_test.sv
`timescale 1ns/1ps
module dual_stage_wdt_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] cnt = 64'h0000_0000_FFFF_FF00;
    logic        bus_kick_frame = 1'b0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        alert;
    logic        trip;

    int checks = 0;
    int failures = 0;

    always #2.5 clk = ~clk;
    always_ff @(posedge clk) cnt <= cnt + 64'd1;

    dual_stage_wdt uut (
        .clk(clk), .rst_n(rst_n), .sys_count(cnt),
        .bus_kick_frame(bus_kick_frame), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .alert(alert), .trip(trip)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Caller is at a falling edge; the access is sampled at the next rising edge.
    task automatic wr(input bit kick, input int addr, input logic [31:0] d,
                      output logic [63:0] c);
        bus_kick_frame = kick; bus_addr = 12'(addr); bus_wdata = d; bus_wr = 1'b1;
        c = cnt;
        @(negedge clk);
        bus_wr = 1'b0; bus_kick_frame = 1'b0;
    endtask

    task automatic rd(input bit kick, input int addr, output logic [31:0] d);
        bus_kick_frame = kick; bus_addr = 12'(addr); bus_rd = 1'b1;
        @(negedge clk);
        d = bus_rdata;
        bus_rd = 1'b0; bus_kick_frame = 1'b0;
    endtask

    task automatic chk_reg(input int addr, input logic [31:0] exp, input string req);
        logic [31:0] v;
        rd(1'b0, addr, v);
        chk(v == exp, req, $sformatf("read @%0h", addr), 64'(v), 64'(exp));
    endtask

    task automatic chk_deadline(input logic [63:0] exp, input string req);
        chk_reg('h010, exp[31:0], req);
        chk_reg('h014, exp[63:32], req);
    endtask

    initial begin
        #(5.0 * 150000);
        failures++;
        $display("FAIL watchdog timeout actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [63:0] c;
        logic [63:0] c2;
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        chk(!alert && !trip, "R1", "outputs after reset", {62'd0, trip, alert}, 64'd0);
        chk_reg('h000, 32'd0, "R1");
        chk_reg('h008, 32'd0, "R1");
        chk_deadline(64'd0, "R1");

        // R6 R7 R5: sweep of small periods
        for (int p = 0; p < 8; p++) begin
            int e1;
            e1 = (p == 0) ? 1 : p;
            wr(1'b0, 'h000, 32'd0, c);
            wr(1'b0, 'h008, 32'(p), c);
            wr(1'b0, 'h000, 32'd1, c);
            for (int k = 1; k <= 2 * e1 + 2; k++) begin
                @(negedge clk);
                chk(alert == (k >= e1), "R6", $sformatf("alert p=%0d k=%0d", p, k),
                    64'(alert), 64'(k >= e1));
                chk(trip == (k >= 2 * e1), "R7", $sformatf("trip p=%0d k=%0d", p, k),
                    64'(trip), 64'(k >= 2 * e1));
            end
            chk_deadline(c + 64'(e1) + 64'(p), "R5");
        end

        // R8: trip stays high, status shows all three bits (R2)
        repeat (30) @(negedge clk);
        chk(alert && trip, "R8", "sticky outputs", {62'd0, trip, alert}, 64'd3);
        chk_reg('h000, 32'h7, "R2");

        // R3: kick frame write with arbitrary data
        wr(1'b1, 'h000, 32'hDEAD_BEEF, c);
        chk(!alert && !trip, "R3", "flags after kick", {62'd0, trip, alert}, 64'd0);
        chk_reg('h000, 32'h1, "R3");
        chk_deadline(c + 64'd7, "R3");

        // R10: refresh in the cycle of first expiry
        wr(1'b0, 'h008, 32'd4, c);
        repeat (3) @(negedge clk);
        wr(1'b1, 'h000, 32'd0, c2);
        chk(c2 == c + 64'd4, "R10", "kick timing", c2, c + 64'd4);
        chk(!alert, "R10", "alert suppressed", 64'(alert), 64'd0);
        chk_deadline(c2 + 64'd4, "R10");

        // R4: period write while enabled acts as refresh with the new value
        wr(1'b1, 'h000, 32'd0, c);
        repeat (6) @(negedge clk);
        chk(alert, "R4", "alert before period write", 64'(alert), 64'd1);
        wr(1'b0, 'h008, 32'd9, c);
        chk(!alert && !trip, "R4", "flags after period write", {62'd0, trip, alert}, 64'd0);
        chk_reg('h008, 32'd9, "R4");
        chk_deadline(c + 64'd9, "R4");

        // R2 and R4: disable write reloads, then period write leaves deadline
        wr(1'b0, 'h000, 32'd0, c);
        chk_reg('h000, 32'h0, "R2");
        wr(1'b0, 'h008, 32'd5, c2);
        chk_deadline(c + 64'd9, "R4");
        chk_reg('h008, 32'd5, "R4");

        // R9: disabled, count runs far past the deadline
        repeat (40) @(negedge clk);
        chk(!alert && !trip, "R9", "no advance while off", {62'd0, trip, alert}, 64'd0);
        chk_reg('h000, 32'h0, "R9");

        // R11: kick frame and unmapped reads return zero; rdata clears after read
        rd(1'b1, 'h000, v);
        chk(v == 32'd0, "R11", "kick frame read", 64'(v), 64'd0);
        rd(1'b0, 'h020, v);
        chk(v == 32'd0, "R11", "unmapped read", 64'(v), 64'd0);
        rd(1'b0, 'h008, v);
        chk(v == 32'd5, "R11", "period read latency", 64'(v), 64'd5);
        @(negedge clk);
        chk(bus_rdata == 32'd0, "R11", "rdata after strobe", 64'(bus_rdata), 64'd0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule